// File: doc/BRIEF.md
# Circular FIFO over dual-port RAM

This block is a single-clock first-in first-out buffer. It keeps its entries in a dual-port RAM: one port writes at a wrapping write pointer, and the other port reads at a wrapping read pointer. It is meant to sit between a serial receiver or transmitter and a protocol consumer. The RAM read is combinational, so the oldest entry is always present on `rd_data` while the buffer holds data. A read request consumes that entry at the next clock edge.

A three-state machine tracks fill status and drives the flags. The states are ST_EMPTY (nothing stored), ST_PART (between one and capacity−1 entries) and ST_FULL (capacity entries). Capacity is 2**AW − 1, because one slot is always left unused.

The machine has five transitions:
- T_FIRST: from ST_EMPTY to ST_PART, taken on an accepted write.
- T_FIRST_FULL: from ST_EMPTY to ST_FULL, taken on a write when the capacity is one.
- T_TOP: from ST_PART to ST_FULL, taken on a write alone that fills the last usable slot.
- T_LAST: from ST_PART to ST_EMPTY, taken on a read alone of the only entry.
- T_RELEASE: from ST_FULL to ST_PART, or from ST_FULL to ST_EMPTY when the capacity is one, taken on an accepted read.

All other cases hold the current state.

Top module: `ringq_fifo`

## Requirements
- R1: After synchronous reset, `empty` is 1, `full` is 0, and both pointers are zero, so the first value written is the first one read.
- R2: Entries leave in the order they were accepted. While the buffer is not empty and no read is requested, `rd_data` stays stable.
- R3: Capacity is 2**AW − 1 entries. `full` rises exactly when that many entries are held, and not earlier.
- R4: A write while `full` is 1 and `rd_en` is 0 is ignored. `full` stays 1 and the stored contents are unchanged.
- R5: A read while `empty` is 1 and `wr_en` is 0 is ignored. `empty` stays 1 and later data is unaffected.
- R6: While the buffer is neither empty nor full, a simultaneous read and write are both accepted, and occupancy and flags stay the same.
- R7: A written value appears on `rd_data` right after the write edge when it is the head entry, with no added read latency.
- R8: When the buffer is empty, a simultaneous read and write accepts only the write. Occupancy becomes 1, and `rd_data` during that cycle is undefined.
- R9: When the buffer is full, a simultaneous read and write accepts only the read. Occupancy becomes capacity − 1 and `full` falls.
- R10: `empty` and `full` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Data to store |
| rd_en | input | 1 | Read request (consume head) |
| rd_data | output | DW | Head entry, combinational from the RAM |
| empty | output | 1 | No entries held |
| full | output | 1 | 2**AW − 1 entries held |

## Verification
Every accepted request changes the flags and the head pointer at the first rising edge after it is driven. The new head value is then on `rd_data` with no further delay, so each result is due one edge after its stimulus. The bench drives inputs on the falling edge and updates its reference queue at the rising edge. It compares `empty`, `full` and `rd_data` at the next falling edge. `rd_data` is compared only while the reference queue holds data, which leaves the undefined case of R8 unchecked.

// File: rtl/ringq_pkg.sv
package ringq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } ringq_state_e;
endpackage

// File: rtl/ringq_ram.sv
// Dual-port storage: one synchronous write port, one combinational read port.
module ringq_ram #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ringq_ptr.sv
// Wrapping pointer; advances by one per step, wraps naturally at 2**AW.
module ringq_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_p1,
    output logic [AW-1:0] ptr_p2
);
    localparam logic [AW-1:0] ONE = AW'(1);

    assign ptr_p1 = ptr + ONE;
    assign ptr_p2 = ptr_p1 + ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr_p1;
        end
    end
endmodule

// File: rtl/ringq_ctrl.sv
// Fill-status state machine: gates requests and drives the flags.
module ringq_ctrl
    import ringq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] wr_ptr_p2,
    input  logic [AW-1:0] rd_ptr,
    input  logic [AW-1:0] rd_ptr_p1,
    output logic          wr_go,
    output logic          rd_go,
    output logic          empty,
    output logic          full
);
    ringq_state_e state_q;
    ringq_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_go) begin
                    // T_FIRST or, at capacity one, T_FIRST_FULL
                    state_d = (wr_ptr_p2 == rd_ptr) ? ST_FULL : ST_PART;
                end
            end
            ST_PART: begin
                if (wr_go && !rd_go && (wr_ptr_p2 == rd_ptr)) begin
                    state_d = ST_FULL;          // T_TOP
                end else if (rd_go && !wr_go && (rd_ptr_p1 == wr_ptr)) begin
                    state_d = ST_EMPTY;         // T_LAST
                end
            end
            ST_FULL: begin
                if (rd_go) begin
                    // T_RELEASE
                    state_d = (rd_ptr_p1 == wr_ptr) ? ST_EMPTY : ST_PART;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        wr_go = 1'b0;
        rd_go = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                empty = 1'b1;
                wr_go = wr_en;
            end
            ST_PART: begin
                wr_go = wr_en;
                rd_go = rd_en;
            end
            ST_FULL: begin
                full  = 1'b1;
                rd_go = rd_en;
            end
            default: begin
                empty = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ringq_fifo.sv
module ringq_fifo #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full
);
    logic [AW-1:0] wr_ptr, wr_ptr_p1, wr_ptr_p2;
    logic [AW-1:0] rd_ptr, rd_ptr_p1, rd_ptr_p2;
    logic          wr_go, rd_go;

    ringq_ptr #(.AW(AW)) u_wptr (
        .clk    (clk),
        .rst    (rst),
        .step   (wr_go),
        .ptr    (wr_ptr),
        .ptr_p1 (wr_ptr_p1),
        .ptr_p2 (wr_ptr_p2)
    );

    ringq_ptr #(.AW(AW)) u_rptr (
        .clk    (clk),
        .rst    (rst),
        .step   (rd_go),
        .ptr    (rd_ptr),
        .ptr_p1 (rd_ptr_p1),
        .ptr_p2 (rd_ptr_p2)
    );

    ringq_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_ptr    (wr_ptr),
        .wr_ptr_p2 (wr_ptr_p2),
        .rd_ptr    (rd_ptr),
        .rd_ptr_p1 (rd_ptr_p1),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .empty     (empty),
        .full      (full)
    );

    ringq_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/ringq_fifo_chk.sv
module ringq_fifo_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          empty,
    input logic          full
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(empty && full)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> empty); // R5
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!empty && !rd_en) |=> $stable(rd_data)); // R2
    AST_MID_BOTH: assert property (@(posedge clk) disable iff (rst)
        (!empty && !full && wr_en && rd_en) |=> (!empty && !full)); // R6
    AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en) |=> !empty); // R8
    AST_FULL_BOTH: assert property (@(posedge clk) disable iff (rst)
        (full && rd_en) |=> !full); // R9
endmodule

bind ringq_fifo ringq_fifo_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (empty),
    .full    (full)
);

// File: tb/ringq_fifo_tb.sv
`timescale 1ns/1ps
module ringq_fifo_tb;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int CAP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [DW-1:0] rd_data;
    logic          empty;
    logic          full;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mdl [CAP];
    int mhead = 0;
    int mcnt  = 0;

    always #5 clk = ~clk;

    ringq_fifo #(.AW(AW), .DW(DW)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .empty   (empty),
        .full    (full)
    );

    function automatic bit exp_empty();
        return mcnt == 0;
    endfunction

    function automatic bit exp_full();
        return mcnt == CAP;
    endfunction

    task automatic check1(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check1({req, " empty"}, longint'(empty), longint'(exp_empty()));
        check1({req, " full"}, longint'(full), longint'(exp_full()));
        if (mcnt > 0) begin
            check1({req, " data"}, longint'(rd_data), longint'(mdl[mhead]));
        end
    endtask

    // Called at a falling edge; result checked at the next falling edge.
    task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r, input string req);
        bit aw, ar;
        wr_en   = w;
        wr_data = d;
        rd_en   = r;
        @(posedge clk);
        aw = w && (mcnt < CAP);
        ar = r && (mcnt > 0);
        if (ar) begin
            mhead = (mhead + 1) % CAP;
            mcnt--;
        end
        if (aw) begin
            mdl[(mhead + mcnt) % CAP] = d;
            mcnt++;
        end
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check_all(req);
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 150000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed    = 32'h5eed;
        void'($urandom(seed));
        rst     = 1'b1;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R7: first write visible immediately; R1: pointers start at zero
        cyc(1'b1, 8'hA5, 1'b0, "R7 R1 first write");
        cyc(1'b0, 8'h00, 1'b1, "R2 drain one");

        // R5: read on empty ignored
        cyc(1'b0, 8'h00, 1'b1, "R5 empty read");
        cyc(1'b0, 8'h00, 1'b1, "R5 empty read again");
        cyc(1'b1, 8'h3C, 1'b0, "R5 data after empty read");

        // R8: empty with both requests
        cyc(1'b0, 8'h00, 1'b1, "R8 prep drain");
        cyc(1'b1, 8'h77, 1'b1, "R8 empty both");

        // R3: fill to capacity
        for (int i = 1; i < CAP; i++) begin
            cyc(1'b1, 8'(8'h10 + i), 1'b0, "R3 fill");
        end
        check1("R3 full at capacity", longint'(full), 1);

        // R4: writes while full are dropped
        cyc(1'b1, 8'hEE, 1'b0, "R4 overflow write");
        cyc(1'b1, 8'hEF, 1'b0, "R4 overflow write again");

        // R9: full with both requests
        cyc(1'b1, 8'hDD, 1'b1, "R9 full both");
        check1("R9 full falls", longint'(full), 0);

        // R6: mid occupancy, both requests
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 8'(8'hC0 + i), 1'b1, "R6 mid both");
        end

        // R2: drain in order
        while (mcnt > 0) begin
            cyc(1'b0, 8'h00, 1'b1, "R2 drain order");
        end

        // Random mix covering all requirements (R10 on flags each cycle)
        for (int i = 0; i < 3000; i++) begin
            int bias;
            bias = (i / 500) % 3;
            cyc(($urandom % 4) < (bias == 0 ? 3 : (bias == 1 ? 1 : 2)),
                8'($urandom), ($urandom % 4) < (bias == 0 ? 1 : (bias == 1 ? 3 : 2)),
                "R10 R2 random");
            checks++;
            if (empty && full) begin
                errors++;
                $display("FAIL R10: actual=both expected=exclusive");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule